// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Serial Slave

This block is the bus front end of a dual digital potentiometer controller. It oversamples the two-wire serial clock and data lines in the system clock domain and detects start and stop conditions. It shifts in the address byte and acknowledges only when that byte carries the fixed device type and the value on four external strap pins. A board can therefore hold up to sixteen of these devices on one bus. Bytes written by the master go to a register back end over a valid/ready handshake. For read transfers, bytes taken from the back end are shifted out most significant bit first.

The data line is open drain: the block only ever pulls it low or lets it go. A write transfer that delivered at least one data byte and that the back end flagged as non-volatile starts a programming window at its stop condition. For the length of that window the block is deaf to the bus. It does not acknowledge its own address and leaves the data line released.

Top module: `dpot_serial_slave`

## Requirements
- R1: After reset, sda_pull_low, busy, rx_valid, tx_take and prog_start are all 0.
- R2: The address byte is sent MSB first. Bits 7..5 hold the device type (parameter DEV_TYPE, default 3'b011), bits 4..1 hold the strap value, and bit 0 is the direction (0 = write, 1 = read). On a match the block pulls the data line low during the ninth clock.
- R3: If the address byte does not match, there is no acknowledge, and no byte is delivered or driven until the next start condition.
- R4: Each write data byte is assembled MSB first and acknowledged. It is then presented on rx_byte with rx_valid high, and rx_valid and rx_byte hold until a cycle with rx_ready high. A byte that arrives while the previous one is still pending is not acknowledged and is dropped.
- R5: In a read transfer the block samples tx_byte and pulses tx_take for one cycle at the start of each byte, then shifts that byte out MSB first. It continues with the next byte only when the master acknowledges, and releases the line after a master not-acknowledge.
- R6: A stop condition that ends a write transfer with at least one data byte while nv_write is 1 gives a one-cycle prog_start pulse. busy then stays high for exactly PROG_CYCLES cycles.
- R7: A stop condition after a read transfer, after a write transfer with no data byte, or while nv_write is 0 gives no prog_start.
- R8: While busy is high the block ignores start conditions, gives no acknowledge even to a matching address and never pulls the data line low.
- R9: A repeated start condition in the middle of a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_addr | input | 4 | Device address strap pins |
| nv_write | input | 1 | Back end flag: the current write transfer targets non-volatile storage |
| rx_byte | output | 8 | Last received write data byte |
| rx_valid | output | 1 | rx_byte holds a byte not yet taken |
| rx_ready | input | 1 | Back end accepts rx_byte |
| tx_byte | input | 8 | Next read data byte from the back end |
| tx_take | output | 1 | One-cycle pulse: tx_byte was captured for sending |
| prog_start | output | 1 | One-cycle pulse: the programming window begins |
| busy | output | 1 | Programming window in progress |

## Verification
The bench builds the block with PROG_CYCLES set to 300 and keeps the default two-stage synchronizer and device type, with a serial clock of twenty system clocks. The short window makes it possible to measure the full busy length to the exact cycle. It is still long enough for a complete address attempt to fall inside it, so the missing acknowledge while busy can be observed. With the default device type, the address vectors can test a wrong type code and wrong strap values side by side.

// File: rtl/dpot_ser_pkg.sv
package dpot_ser_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 4;
  localparam int TYPE_W  = BYTE_W - STRAP_W - 1;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ADDR,
    SL_AACK,
    SL_WDAT,
    SL_WACK,
    SL_RDAT,
    SL_RACK
  } slv_state_e;
endpackage

// File: rtl/bus_cond_det.sv
module bus_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  // idle bus is high, so the chains reset high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/prog_lockout.sv
module prog_lockout #(
  parameter int PROG_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_start,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (prog_start) begin
      busy   <= 1'b1;
      remain <= LAST;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/slave_fsm.sv
module slave_fsm
  import dpot_ser_pkg::*;
#(
  parameter logic [TYPE_W-1:0] DEV_TYPE = 3'b011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               busy,
  input  logic               nv_write,
  input  logic               rx_ready,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic               sda_pull_low,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               rx_valid,
  output logic               tx_take,
  output logic               prog_start
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  slv_state_e        state;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              is_rd, wr_sel, got_data, mack;
  logic              addr_hit;

  assign addr_hit = (sh[BYTE_W-1:1] == {DEV_TYPE, strap_addr});

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SL_IDLE;
      sh           <= '0;
      cnt          <= '0;
      is_rd        <= 1'b0;
      wr_sel       <= 1'b0;
      got_data     <= 1'b0;
      mack         <= 1'b0;
      sda_pull_low <= 1'b0;
      rx_byte      <= '0;
      rx_valid     <= 1'b0;
      tx_take      <= 1'b0;
      prog_start   <= 1'b0;
    end else begin
      tx_take    <= 1'b0;
      prog_start <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (busy) begin
        state        <= SL_IDLE;
        sda_pull_low <= 1'b0;
        wr_sel       <= 1'b0;
        got_data     <= 1'b0;
      end else if (start_det) begin
        state        <= SL_ADDR;
        cnt          <= '0;
        sda_pull_low <= 1'b0;
        is_rd        <= 1'b0;
        wr_sel       <= 1'b0;
        got_data     <= 1'b0;
      end else if (stop_det) begin
        prog_start   <= wr_sel & got_data & nv_write;
        state        <= SL_IDLE;
        sda_pull_low <= 1'b0;
        wr_sel       <= 1'b0;
        got_data     <= 1'b0;
      end else begin
        unique case (state)
          SL_ADDR, SL_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == SL_ADDR) begin
                if (addr_hit) begin
                  state        <= SL_AACK;
                  sda_pull_low <= 1'b1;
                  is_rd        <= sh[0];
                  wr_sel       <= ~sh[0];
                end else begin
                  state <= SL_IDLE;
                end
              end else begin
                state <= SL_WACK;
                if (!rx_valid || rx_ready) begin
                  rx_byte      <= sh;
                  rx_valid     <= 1'b1;
                  got_data     <= 1'b1;
                  sda_pull_low <= 1'b1;
                end
              end
            end
          end
          SL_AACK, SL_WACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (state == SL_AACK && is_rd) begin
                sh           <= tx_byte;
                tx_take      <= 1'b1;
                sda_pull_low <= ~tx_byte[BYTE_W-1];
                state        <= SL_RDAT;
              end else begin
                sda_pull_low <= 1'b0;
                state        <= SL_WDAT;
              end
            end
          end
          SL_RDAT: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_pull_low <= 1'b0;
                state        <= SL_RACK;
              end else begin
                sh           <= {sh[BYTE_W-2:0], 1'b0};
                sda_pull_low <= ~sh[BYTE_W-2];
                cnt          <= cnt + 1'b1;
              end
            end
          end
          SL_RACK: begin
            if (scl_rise) mack <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack) begin
                sh           <= tx_byte;
                tx_take      <= 1'b1;
                sda_pull_low <= ~tx_byte[BYTE_W-1];
                cnt          <= '0;
                state        <= SL_RDAT;
              end else begin
                state <= SL_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_serial_slave.sv
module dpot_serial_slave
  import dpot_ser_pkg::*;
#(
  parameter logic [TYPE_W-1:0] DEV_TYPE    = 3'b011,
  parameter int                SYNC_STAGES = 2,
  parameter int                PROG_CYCLES = 500000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_low,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               nv_write,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               rx_valid,
  input  logic               rx_ready,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic               tx_take,
  output logic               prog_start,
  output logic               busy
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  bus_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  slave_fsm #(.DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .sda_lvl      (sda_lvl),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .strap_addr   (strap_addr),
    .busy         (busy),
    .nv_write     (nv_write),
    .rx_ready     (rx_ready),
    .tx_byte      (tx_byte),
    .sda_pull_low (sda_pull_low),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .tx_take      (tx_take),
    .prog_start   (prog_start)
  );

  prog_lockout #(.PROG_CYCLES(PROG_CYCLES)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .prog_start (prog_start),
    .busy       (busy)
  );
endmodule

// File: rtl/dpot_serial_slave_chk.sv
module dpot_serial_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       sda_pull_low,
  input logic       busy,
  input logic       prog_start,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_byte,
  input logic       tx_take
);
  assert_busy_silent_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull_low);

  assert_prog_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !busy);

  assert_prog_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> busy);

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_byte)));

  assert_take_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    tx_take |-> !busy);
endmodule

bind dpot_serial_slave dpot_serial_slave_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sda_pull_low (sda_pull_low),
  .busy         (busy),
  .prog_start   (prog_start),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_byte      (rx_byte),
  .tx_take      (tx_take)
);

// File: tb/dpot_serial_slave_tb.sv
`timescale 1ns/1ps
module dpot_serial_slave_tb;
  localparam int PROG = 300;
  localparam int Q    = 5;
  localparam int NV   = 10;
  // {strap[3:0], address byte[7:0], expected ack}
  localparam logic [12:0] VEC [NV] = '{
    {4'h5, 8'h6A, 1'b1}, {4'h5, 8'h6C, 1'b0}, {4'h0, 8'h60, 1'b1},
    {4'hF, 8'h7E, 1'b1}, {4'hF, 8'h7C, 1'b0}, {4'hA, 8'h74, 1'b1},
    {4'hA, 8'h54, 1'b0}, {4'h3, 8'h66, 1'b1}, {4'h3, 8'hE6, 1'b0},
    {4'h9, 8'h72, 1'b1}};

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, rx_valid, tx_take, prog_start, busy;
  logic [3:0] strap = 4'h5;
  logic nv_write = 1'b0, rx_ready = 1'b1;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte = 8'hC3;
  logic sda_line;

  int checks = 0, fails = 0;
  int rx_cnt = 0, tx_cnt = 0, prog_cnt = 0, busy_run = 0, busy_len = 0;
  logic [7:0] rx_log [16];
  logic busy_prev = 1'b0;
  logic ack;
  logic [7:0] rd;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_low;

  dpot_serial_slave #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .strap_addr(strap), .nv_write(nv_write),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_take(tx_take), .prog_start(prog_start), .busy(busy));

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && rx_ready) begin
        rx_log[rx_cnt % 16] = rx_byte;
        rx_cnt++;
      end
      if (tx_take) begin
        tx_cnt++;
        tx_byte = tx_byte + 8'd1;
      end
      if (prog_start) prog_cnt++;
      if (busy) busy_run++;
      else if (busy_prev) begin
        busy_len = busy_run;
        busy_run = 0;
      end
      busy_prev = busy;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wq(); scl = 1'b1; wq(); seen = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic a);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    a = ~s;
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sda_pull_low", sda_pull_low, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 prog_start/tx_take", {prog_start, tx_take}, 0);

    // R2/R3 address vectors
    for (int k = 0; k < NV; k++) begin
      strap = VEC[k][12:9];
      bus_start();
      send_byte(VEC[k][8:1], ack);
      bus_stop();
      chk(VEC[k][0] ? "R2 ack on match" : "R3 no ack on mismatch", ack, VEC[k][0]);
    end
    chk("R7 no prog without data", prog_cnt, 0);
    chk("R3 no bytes from vectors", rx_cnt, 0);

    // R4 write two bytes
    strap = 4'h5;
    bus_start(); send_byte(8'h6A, ack);
    send_byte(8'hA5, ack); chk("R4 ack byte1", ack, 1);
    send_byte(8'h3C, ack); chk("R4 ack byte2", ack, 1);
    bus_stop();
    chk("R4 rx count", rx_cnt, 2);
    chk("R4 byte1", rx_log[0], 8'hA5);
    chk("R4 byte2", rx_log[1], 8'h3C);
    chk("R7 nv_write low no prog", prog_cnt, 0);

    // R4 hold while not ready
    rx_ready = 1'b0;
    bus_start(); send_byte(8'h6A, ack);
    send_byte(8'h81, ack);
    repeat (10) @(negedge clk);
    chk("R4 valid held", rx_valid, 1);
    chk("R4 byte held", rx_byte, 8'h81);
    rx_ready = 1'b1;
    bus_stop();
    chk("R4 handshake after ready", rx_cnt, 3);

    // R3 mismatch then data ignored
    bus_start(); send_byte(8'h6C, ack); send_byte(8'hFF, ack);
    chk("R3 data after mismatch not acked", ack, 0);
    bus_stop();
    chk("R3 no byte delivered", rx_cnt, 3);

    // R9 repeated start
    bus_start(); send_byte(8'h6C, ack);
    bus_start(); send_byte(8'h6A, ack);
    chk("R9 ack after repeated start", ack, 1);
    send_byte(8'h5A, ack);
    bus_stop();
    chk("R9 byte after repeated start", rx_log[3], 8'h5A);

    // R5 read
    bus_start(); send_byte(8'h6B, ack);
    chk("R5 read address ack", ack, 1);
    read_byte(1'b1, rd); chk("R5 first read byte", rd, 8'hC3);
    read_byte(1'b0, rd); chk("R5 second read byte", rd, 8'hC4);
    bus_stop();
    chk("R5 tx_take count", tx_cnt, 2);

    // R7 read / zero-data write with nv_write high
    nv_write = 1'b1;
    bus_start(); send_byte(8'h6B, ack); read_byte(1'b0, rd); bus_stop();
    bus_start(); send_byte(8'h6A, ack); bus_stop();
    repeat (4) @(negedge clk);
    chk("R7 no prog for read or empty write", prog_cnt, 0);

    // R6 programming window
    base = rx_cnt;
    bus_start(); send_byte(8'h6A, ack); send_byte(8'h12, ack); bus_stop();
    repeat (4) @(negedge clk);
    chk("R6 prog pulse", prog_cnt, 1);
    chk("R6 busy", busy, 1);
    // R8 silent while busy
    bus_start(); send_byte(8'h6A, ack); bus_stop();
    chk("R8 no ack while busy", ack, 0);
    chk("R8 still busy", busy, 1);
    chk("R8 no byte while busy", rx_cnt, base + 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R6 busy length", busy_len, PROG);
    nv_write = 1'b0;
    bus_start(); send_byte(8'h6A, ack); bus_stop();
    chk("R6 ack after window", ack, 1);
    chk("R6 single prog pulse", prog_cnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule